// File: doc/BRIEF.md
# Iterative ARX Block Cipher Core

This core encrypts or decrypts one 128-bit block per request with a 32-bit add-rotate-xor round function. The round function mixes each word with a quadratic term, x·(2x+1) rotated left by five. Each 32-bit word is also rotated by an amount that the data sets. The block is held as four 32-bit working words. A, the first word, sits in bits 31:0 of the data ports and D, the last, in bits 127:96. A direction input selects the mode when a request starts. One round completes per clock. A whitening step comes before the rounds and another after them, so a result takes ROUNDS+2 cycles.

The round keys come from an external table that is already filled. The core drives a pair index `rk_pair_o`. The table answers in the same cycle with key word 2p on `rk_even_i` and key word 2p+1 on `rk_odd_i`. Key expansion, padding and chaining are left to the surrounding logic.

Top module: `arx_cipher_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy_o` and `done_o` are 0 and `data_o` is all zeros.
- R2: A high `start_i` sampled while `busy_o` is low is accepted. `busy_o` is 1 in the next cycle. The direction is taken from `decrypt_i` in that same cycle: 0 selects encryption and 1 selects decryption.
- R3: After an accepted start, `busy_o` stays high for exactly ROUNDS+2 cycles. `done_o` is then high for one cycle, and in that cycle `busy_o` is low.
- R4: Encryption first adds key 0 to B and key 1 to D. Each round i, from 1 to ROUNDS, then does the following. It sets t = rotl(B·(2B+1), 5) and u = rotl(D·(2D+1), 5). It sets A = rotl(A xor t, u[4:0]) + key 2i and C = rotl(C xor u, t[4:0]) + key 2i+1. It then moves the words so that (A,B,C,D) becomes (B,C,D,A). After the last round, A gains key 2·ROUNDS+2 and C gains key 2·ROUNDS+3. All arithmetic is modulo 2^32.
- R5: Decryption first subtracts key 2·ROUNDS+3 from C and key 2·ROUNDS+2 from A. It then runs rounds i from ROUNDS down to 1. Each round first moves the words so that (A,B,C,D) becomes (D,A,B,C). It then sets C = rotr(C − key 2i+1, t[4:0]) xor u and A = rotr(A − key 2i, u[4:0]) xor t, with t and u formed from B and D as in R4. At the end, key 1 is subtracted from D and key 0 from B.
- R6: While busy, `rk_pair_o` gives the pair in use. For encryption the sequence is 0, then 1 up to ROUNDS, then ROUNDS+1. For decryption it is ROUNDS+1, then ROUNDS down to 1, then 0.
- R7: While busy, changes on `start_i`, `decrypt_i` and `data_i` do not affect the request in flight or its result.
- R8: `data_o` changes only in the cycle in which `done_o` is high. It holds the last result until the next completion.
- R9: Decrypting the ciphertext of a block with the same key table returns the original block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a block operation |
| decrypt_i | input | 1 | Direction for the request: 1 decrypts, 0 encrypts |
| data_i | input | 128 | Input block, word A in bits 31:0 |
| rk_pair_o | output | 5 | Round-key pair index p |
| rk_even_i | input | 32 | Key word 2p from the table |
| rk_odd_i | input | 32 | Key word 2p+1 from the table |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 128 | Result block, word A in bits 31:0 |

## Verification
A wrong bit in a working word spreads through the quadratic mixing and the data-dependent rotations. It therefore corrupts nearly the whole output block, but this only becomes visible at the `done_o` pulse, ROUNDS+2 cycles after the start. A sequencer fault shows much sooner. A skipped or repeated pair index shows up in the cycle it happens, because `rk_pair_o` is compared against the expected schedule every clock. A phase or counter error moves `busy_o` or `done_o` off the predicted cycle. A leak of mid-request inputs into the operation shows up as a wrong result at completion.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned ROT_W     = $clog2(WORD_W);
    localparam int unsigned NUM_WORDS = 4;
    localparam int unsigned BLOCK_W   = WORD_W * NUM_WORDS;

    // word slots inside the working quad
    localparam int unsigned WA = 0;
    localparam int unsigned WB = 1;
    localparam int unsigned WC = 2;
    localparam int unsigned WD = 3;

    typedef logic [WORD_W-1:0]          word_t;
    typedef word_t [NUM_WORDS-1:0]      quad_t;
    typedef logic [ROT_W-1:0]           shamt_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_ROUND,
        PH_POST
    } phase_e;

    function automatic word_t rotl(word_t x, shamt_t s);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << s;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t rotr(word_t x, shamt_t s);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} >> s;
        return dbl[WORD_W-1:0];
    endfunction

    // quadratic mixing term, rotated by log2 of the word width
    function automatic word_t mixq(word_t x);
        word_t prod;
        prod = x * ((x << 1) | word_t'(1));
        return rotl(prod, shamt_t'(ROT_W));
    endfunction

endpackage

// File: rtl/arx_seq.sv
module arx_seq
    import arx_pkg::*;
#(
    parameter int unsigned ROUNDS = 20,
    parameter int unsigned IDX_W  = $clog2(ROUNDS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             decrypt_i,
    output phase_e           phase_o,
    output logic             dec_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] FIRST_RND = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST_RND  = IDX_W'(ROUNDS);
    localparam logic [IDX_W-1:0] TAIL_IDX  = IDX_W'(ROUNDS + 1);
    localparam int unsigned      LAT_W     = $clog2(ROUNDS + 3) + 1;

    typedef struct packed {
        phase_e           phase;
        logic             dec;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_rnd;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        last_rnd   = seq_q.dec ? (seq_q.idx == FIRST_RND) : (seq_q.idx == LAST_RND);
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_PRE;
                    seq_d.dec   = decrypt_i;
                    seq_d.idx   = decrypt_i ? TAIL_IDX : '0;
                end
            end
            PH_PRE: begin
                seq_d.phase = PH_ROUND;
                seq_d.idx   = seq_q.dec ? LAST_RND : FIRST_RND;
            end
            PH_ROUND: begin
                if (last_rnd) begin
                    seq_d.phase = PH_POST;
                    seq_d.idx   = seq_q.dec ? '0 : TAIL_IDX;
                end else if (seq_q.dec) begin
                    seq_d.idx = seq_q.idx - FIRST_RND;
                end else begin
                    seq_d.idx = seq_q.idx + FIRST_RND;
                end
            end
            PH_POST: begin
                seq_d.phase = PH_IDLE;
                seq_d.idx   = '0;
                seq_d.done  = 1'b1;
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, dec: 1'b0, idx: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign dec_o   = seq_q.dec;
    assign idx_o   = seq_q.idx;
    assign busy_o  = (seq_q.phase != PH_IDLE);
    assign done_o  = seq_q.done;

    // cycles since the last accepted start, used by the latency check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (!busy_o && start_i) begin
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == LAT_W'(ROUNDS + 2)));

    a_r6_enc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_ROUND && $past(phase_o) == PH_ROUND && !dec_o)
            |-> (idx_o == $past(idx_o) + 1'b1));

    a_r6_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_ROUND && $past(phase_o) == PH_ROUND && dec_o)
            |-> (idx_o == $past(idx_o) - 1'b1));

    a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_o != PH_POST) |=> $stable(dec_o));

endmodule

// File: rtl/arx_round.sv
module arx_round
    import arx_pkg::*;
(
    input  phase_e phase_i,
    input  logic   dec_i,
    input  quad_t  cur_i,
    input  word_t  key_even_i,
    input  word_t  key_odd_i,
    output quad_t  nxt_o
);

    word_t t_enc, u_enc, a_enc, c_enc;
    word_t t_dec, u_dec, a_dec, c_dec;

    // forward round on the current words
    always_comb begin
        t_enc = mixq(cur_i[WB]);
        u_enc = mixq(cur_i[WD]);
        a_enc = rotl(cur_i[WA] ^ t_enc, u_enc[ROT_W-1:0]) + key_even_i;
        c_enc = rotl(cur_i[WC] ^ u_enc, t_enc[ROT_W-1:0]) + key_odd_i;
    end

    // inverse round: after the word shift, B is old A and D is old C
    always_comb begin
        t_dec = mixq(cur_i[WA]);
        u_dec = mixq(cur_i[WC]);
        c_dec = rotr(cur_i[WB] - key_odd_i,  t_dec[ROT_W-1:0]) ^ u_dec;
        a_dec = rotr(cur_i[WD] - key_even_i, u_dec[ROT_W-1:0]) ^ t_dec;
    end

    always_comb begin
        nxt_o = cur_i;
        unique case (phase_i)
            PH_PRE: begin
                if (dec_i) begin
                    nxt_o[WA] = cur_i[WA] - key_even_i;
                    nxt_o[WC] = cur_i[WC] - key_odd_i;
                end else begin
                    nxt_o[WB] = cur_i[WB] + key_even_i;
                    nxt_o[WD] = cur_i[WD] + key_odd_i;
                end
            end
            PH_ROUND: begin
                if (dec_i) begin
                    nxt_o[WA] = a_dec;
                    nxt_o[WB] = cur_i[WA];
                    nxt_o[WC] = c_dec;
                    nxt_o[WD] = cur_i[WC];
                end else begin
                    nxt_o[WA] = cur_i[WB];
                    nxt_o[WB] = c_enc;
                    nxt_o[WC] = cur_i[WD];
                    nxt_o[WD] = a_enc;
                end
            end
            PH_POST: begin
                if (dec_i) begin
                    nxt_o[WB] = cur_i[WB] - key_even_i;
                    nxt_o[WD] = cur_i[WD] - key_odd_i;
                end else begin
                    nxt_o[WA] = cur_i[WA] + key_even_i;
                    nxt_o[WC] = cur_i[WC] + key_odd_i;
                end
            end
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/arx_cipher_core.sv
module arx_cipher_core
    import arx_pkg::*;
#(
    parameter int unsigned ROUNDS = 20,
    parameter int unsigned PAIR_W = $clog2(ROUNDS + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               decrypt_i,
    input  logic [BLOCK_W-1:0] data_i,
    output logic [PAIR_W-1:0]  rk_pair_o,
    input  logic [WORD_W-1:0]  rk_even_i,
    input  logic [WORD_W-1:0]  rk_odd_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [BLOCK_W-1:0] data_o
);

    typedef struct packed {
        quad_t work;
        quad_t res;
    } dp_t;

    phase_e phase;
    logic   dec;
    quad_t  in_words;
    quad_t  step_words;
    dp_t    dp_d, dp_q;

    arx_seq #(
        .ROUNDS (ROUNDS),
        .IDX_W  (PAIR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .phase_o   (phase),
        .dec_o     (dec),
        .idx_o     (rk_pair_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    arx_round u_round (
        .phase_i    (phase),
        .dec_i      (dec),
        .cur_i      (dp_q.work),
        .key_even_i (rk_even_i),
        .key_odd_i  (rk_odd_i),
        .nxt_o      (step_words)
    );

    // little-endian word packing on both data ports
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pack
        assign in_words[g]                 = data_i[g*WORD_W +: WORD_W];
        assign data_o[g*WORD_W +: WORD_W]  = dp_q.res[g];
    end

    always_comb begin
        dp_d = dp_q;
        if (phase == PH_IDLE) begin
            if (start_i) begin
                dp_d.work = in_words;
            end
        end else begin
            dp_d.work = step_words;
        end
        if (phase == PH_POST) begin
            dp_d.res = step_words;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (dp_q.work == $past(in_words)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));

    a_r6_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rk_pair_o <= PAIR_W'(ROUNDS + 1)));

endmodule

// File: tb/arx_cipher_core_tb_top.sv
module arx_cipher_core_tb_top;

    localparam int R    = 20;
    localparam int NKEY = 2 * R + 4;
    localparam int PW   = $clog2(R + 2);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          dec;
    logic [127:0]  din;
    logic [PW-1:0] pair;
    logic [31:0]   kev, kod;
    logic          busy, done;
    logic [127:0]  dout;
    logic [31:0]   skey [NKEY];

    int checks = 0;
    int fails  = 0;

    // model state (value expected after the coming edge)
    int           rem    = 0;
    bit           mbusy  = 0;
    bit           mdone  = 0;
    bit           mdec   = 0;
    bit           noisy  = 0;
    logic [127:0] mres   = '0;
    logic [127:0] mout   = '0;

    always #5ns clk = ~clk;

    assign kev = skey[2 * pair];
    assign kod = skey[2 * pair + 1];

    arx_cipher_core #(.ROUNDS(R)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .decrypt_i (dec),
        .data_i    (din),
        .rk_pair_o (pair),
        .rk_even_i (kev),
        .rk_odd_i  (kod),
        .busy_o    (busy),
        .done_o    (done),
        .data_o    (dout)
    );

    function automatic logic [31:0] brol(logic [31:0] x, int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] bror(logic [31:0] x, int n);
        if (n == 0) return x;
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [31:0] bmix(logic [31:0] x);
        logic [31:0] p;
        p = x * (2 * x + 1);
        return brol(p, 5);
    endfunction

    function automatic logic [127:0] ref_enc(logic [127:0] blk);
        logic [31:0] a, b, c, d, t, u, tmp;
        {d, c, b, a} = blk;
        b = b + skey[0];
        d = d + skey[1];
        for (int i = 1; i <= R; i++) begin
            t = bmix(b);
            u = bmix(d);
            a = brol(a ^ t, int'(u[4:0])) + skey[2 * i];
            c = brol(c ^ u, int'(t[4:0])) + skey[2 * i + 1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + skey[2 * R + 2];
        c = c + skey[2 * R + 3];
        return {d, c, b, a};
    endfunction

    function automatic logic [127:0] ref_dec(logic [127:0] blk);
        logic [31:0] a, b, c, d, t, u, tmp;
        {d, c, b, a} = blk;
        c = c - skey[2 * R + 3];
        a = a - skey[2 * R + 2];
        for (int i = R; i >= 1; i--) begin
            tmp = d; d = c; c = b; b = a; a = tmp;
            u = bmix(d);
            t = bmix(b);
            c = bror(c - skey[2 * i + 1], int'(t[4:0])) ^ u;
            a = bror(a - skey[2 * i], int'(u[4:0])) ^ t;
        end
        d = d - skey[1];
        b = b - skey[0];
        return {d, c, b, a};
    endfunction

    function automatic int exp_pair();
        if (rem == R + 2) return mdec ? R + 1 : 0;
        if (rem == 1)     return mdec ? 0 : R + 1;
        return mdec ? rem - 1 : R + 2 - rem;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs, advance the model, compare after the edge
    task automatic step(input bit st, input bit dc, input logic [127:0] d);
        start = st;
        dec   = dc;
        din   = d;
        mdone = 0;
        if (rem > 0) begin
            if (st) noisy = 1;
            rem--;
            if (rem == 0) begin
                mbusy = 0;
                mdone = 1;
                mout  = mres;
            end
        end else if (st) begin
            rem   = R + 2;
            mbusy = 1;
            mdec  = dc;
            noisy = 0;
            mres  = dc ? ref_dec(d) : ref_enc(d);
        end
        @(negedge clk);
        chk((mbusy && rem == R + 2) ? "R2 busy" : "R3 busy", 128'(busy), 128'(mbusy));
        chk("R3 done", 128'(done), 128'(mdone));
        if (mdone)
            chk(noisy ? "R7 result" : (mdec ? "R5 result" : "R4 result"), dout, mout);
        else
            chk("R8 hold", dout, mout);
        if (mbusy) chk("R6 pair", 128'(pair), 128'(exp_pair()));
    endtask

    task automatic run_op(input bit dc, input logic [127:0] d, input bit with_noise,
                          output logic [127:0] res);
        step(1'b1, dc, d);
        while (!mdone) begin
            if (with_noise)
                step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     {$urandom, $urandom, $urandom, $urandom});
            else
                step(1'b0, dc, d);
        end
        res = dout;
    endtask

    initial begin
        logic [127:0] ct, pt, back;
        for (int k = 0; k < NKEY; k++)
            skey[k] = (32'(k) * 32'h9E3779B9) ^ 32'hB7E15163 ^ (32'(k) << 11);
        rst_n = 1'b0;
        start = 1'b0;
        dec   = 1'b0;
        din   = '0;
        repeat (2) @(negedge clk);
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 done", 128'(done), 128'(0));
        chk("R1 data", dout, 128'(0));
        rst_n = 1'b1;
        step(1'b0, 1'b0, '0);
        chk("R1 data after release", dout, 128'(0));

        // R4: encryption on several patterns
        run_op(1'b0, 128'h0, 1'b0, ct);
        run_op(1'b0, {128{1'b1}}, 1'b0, ct);
        step(1'b0, 1'b0, '0);
        run_op(1'b0, 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, 1'b0, ct);
        // R5: decryption, started in the done cycle of the previous run
        run_op(1'b1, 128'h01234567_89ABCDEF_FEDCBA98_76543210, 1'b0, pt);
        step(1'b0, 1'b0, '0);

        // R9: round trips, some with mid-request noise (R7)
        for (int n = 0; n < 4; n++) begin
            pt = {$urandom, $urandom, $urandom, $urandom};
            run_op(1'b0, pt, n[0], ct);
            step(1'b0, 1'b0, '0);
            run_op(1'b1, ct, n[1], back);
            chk("R9 round trip", back, pt);
            repeat (2) step(1'b0, 1'b1, {$urandom, $urandom, $urandom, $urandom});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500us;
        checks++;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule